// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a nine-bit first-in first-out buffer with a write clock and a read clock of its own. The two clocks may be one net or fully unrelated. Writing and reading may happen in the same cycle. Storage is a dual-port array indexed by binary pointers. Each pointer carries one extra wrap bit and crosses into the other domain as a Gray code through a chain of synchronizer flops.

The write side has two qualifiers. The first, `wen1_n`, is active low. The second, `wen2_ld`, selects the operation:
- `wen2_ld` high with `wen1_n` low stores a word.
- `wen2_ld` low with `wen1_n` low loads a threshold value from `din`.

Threshold loads alternate between the near-empty threshold and the near-full threshold. The read side needs two active-low qualifiers together, and its data passes through an output register. An active-low output enable forces the visible data to zero when deasserted.

The empty flag and the near-empty flag come from the read clock domain. The full flag and the near-full flag come from the write clock domain. An asynchronous active-low reset clears the buffer and restores both thresholds to their default. Inside each domain the reset is released synchronously.

Top module: `dcfifo_pflag`

## Requirements
- R1: On a rising write-clock edge with `wen1_n`=0, `wen2_ld`=1 and `full`=0, `din` is stored. Words are returned in the order written, one per cycle while the enables stay active. With `wen1_n`=1 nothing is stored.
- R2: A word is read on a rising read-clock edge only when both `ren1_n`=0 and `ren2_n`=0 (and `empty`=0). With either one high, the read pointer and the output register keep their values.
- R3: A write attempt while `full`=1 changes nothing. A read attempt while `empty`=1 changes nothing, and the output register keeps the last word read.
- R4: Once the pointers have settled, `empty`=1 exactly when the occupancy is 0, and `full`=1 exactly when the occupancy equals DEPTH (default 64).
- R5: Once settled, `aempty`=1 exactly when the occupancy is less than or equal to the near-empty threshold.
- R6: Once settled, `afull`=1 exactly when DEPTH minus the occupancy is less than or equal to the near-full threshold.
- R7: With `wen1_n`=0 and `wen2_ld`=0, each rising write-clock edge copies `din` into a threshold and stores no word. The first load goes to the near-empty threshold, the second to the near-full threshold, and the sequence then wraps.
- R8: With `oe_n`=1, `dout` is all zeros. With `oe_n`=0, `dout` shows the output register.
- R9: `rst_n`=0 empties the buffer (`empty`=1, `aempty`=1, `full`=0, `afull`=0), clears the output register, sets both thresholds to 7, and points the load sequence back at the near-empty threshold.
- R10: With the clocks tied, a write and a read in the same cycle each take effect. With independent clocks of unrelated period, every word is delivered intact and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock (may be tied to wclk) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wen1_n | input | 1 | Write qualifier, active low |
| wen2_ld | input | 1 | High: store word; low: load threshold |
| din | input | DATA_W | Write data or threshold value |
| ren1_n | input | 1 | Read qualifier one, active low |
| ren2_n | input | 1 | Read qualifier two, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Read data, zero when disabled |
| empty | output | 1 | Buffer empty (read domain) |
| full | output | 1 | Buffer full (write domain) |
| aempty | output | 1 | Occupancy at or under near-empty threshold |
| afull | output | 1 | Free space at or under near-full threshold |

## Verification
The buffer is filled one word at a time from empty to full and then drained back to empty. All four flags are checked against the arithmetic occupancy at every level, so each threshold edge is seen from both sides.

A second threshold pair loaded through the wrapping sequence shows which register each load reached. A threshold load right after reset shows that the sequence restarted. Half-qualified reads and writes, a write into a full buffer and a read from an empty one are each followed by a drain or a flag check, which shows that they had no effect.

Back-to-back combined read and write with tied clocks separates a design that serializes the two operations from one that handles both in a cycle. A run with unrelated clock periods exposes faults in the pointer crossing through word order.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  // Pointer conversions operate on a fixed width; callers zero-extend.
  localparam int PTR_MAX_W = 16;

  typedef enum logic {
    SEL_NEAR_EMPTY = 1'b0,
    SEL_NEAR_FULL  = 1'b1
  } thr_sel_e;

  function automatic logic [PTR_MAX_W-1:0] bin_to_gray(input logic [PTR_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX_W-1:0] gray_to_bin(input logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] cell_q [WORDS];

  always_ff @(posedge wclk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 9,
  parameter int OFS_RESET = 7
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   rgray_s,
  output logic          wr_en,
  output logic [AW:0]   wptr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull,
  output logic [DW-1:0] ae_thr,
  output logic [DW-1:0] af_thr
);
  localparam int            PW     = AW + 1;
  localparam logic [PW-1:0] CAP    = PW'(1 << AW);
  localparam logic [DW-1:0] THR_RV = DW'(OFS_RESET);

  logic [PW-1:0] rptr_s, occ, space;
  logic [PW-1:0] wptr_d, wgray_d;
  logic [DW-1:0] ae_thr_d, af_thr_d;
  thr_sel_e      sel_q, sel_d;
  logic          wr_req, ld_req;

  // Occupancy seen from the write side, against the synchronized read pointer
  always_comb begin
    rptr_s = PW'(gray_to_bin(PTR_MAX_W'(rgray_s)));
    occ    = wptr - rptr_s;
    space  = CAP - occ;
    full   = (occ == CAP);
    afull  = (32'(space) <= 32'(af_thr));
  end

  // Next-state decode
  always_comb begin
    wr_req   = !wen1_n && wen2_ld;
    ld_req   = !wen1_n && !wen2_ld;
    wr_en    = wr_req && !full;
    wptr_d   = wptr;
    ae_thr_d = ae_thr;
    af_thr_d = af_thr;
    sel_d    = sel_q;
    if (wr_en) begin
      wptr_d = wptr + PW'(1);
    end
    if (ld_req) begin
      if (sel_q == SEL_NEAR_EMPTY) begin
        ae_thr_d = din;
        sel_d    = SEL_NEAR_FULL;
      end else begin
        af_thr_d = din;
        sel_d    = SEL_NEAR_EMPTY;
      end
    end
    wgray_d = PW'(bin_to_gray(PTR_MAX_W'(wptr_d)));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr   <= '0;
      wgray  <= '0;
      ae_thr <= THR_RV;
      af_thr <= THR_RV;
      sel_q  <= SEL_NEAR_EMPTY;
    end else begin
      wptr   <= wptr_d;
      wgray  <= wgray_d;
      ae_thr <= ae_thr_d;
      af_thr <= af_thr_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic [AW:0]   wgray_s,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] ae_thr,
  output logic          rd_en,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] dout_q,
  output logic          empty,
  output logic          aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_s, occ;
  logic [PW-1:0] rptr_d, rgray_d;
  logic [DW-1:0] dout_d;

  // Occupancy seen from the read side, against the synchronized write pointer
  always_comb begin
    wptr_s = PW'(gray_to_bin(PTR_MAX_W'(wgray_s)));
    occ    = wptr_s - rptr;
    empty  = (rptr == wptr_s);
    aempty = (32'(occ) <= 32'(ae_thr));
  end

  always_comb begin
    rd_en   = !ren1_n && !ren2_n && !empty;
    rptr_d  = rptr;
    dout_d  = dout_q;
    if (rd_en) begin
      rptr_d = rptr + PW'(1);
      dout_d = rdata;
    end
    rgray_d = PW'(bin_to_gray(PTR_MAX_W'(rptr_d)));
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      dout_q <= '0;
    end else begin
      rptr   <= rptr_d;
      rgray  <= rgray_d;
      dout_q <= dout_d;
    end
  end
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
  parameter int DEPTH       = 64,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_RESET   = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic [DATA_W-1:0] din,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic              aempty,
  output logic              afull
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              w_rst_n, r_rst_n;
  logic              wr_en, rd_en;
  logic [PW-1:0]     wptr_w, wgray_w, rptr_r, rgray_r;
  logic [PW-1:0]     wgray_to_r, rgray_to_w;
  logic [DATA_W-1:0] ae_thr, af_thr, rdata, dout_q;

  dcf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(w_rst_n));
  dcf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(r_rst_n));

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst_n(r_rst_n), .d(wgray_w), .q(wgray_to_r)
  );
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst_n(w_rst_n), .d(rgray_r), .q(rgray_to_w)
  );

  dcf_wr_ctrl #(.AW(AW), .DW(DATA_W), .OFS_RESET(OFS_RESET)) u_wr (
    .wclk(wclk), .wrst_n(w_rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .rgray_s(rgray_to_w), .wr_en(wr_en), .wptr(wptr_w),
    .wgray(wgray_w), .full(full), .afull(afull),
    .ae_thr(ae_thr), .af_thr(af_thr)
  );

  dcf_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .wclk(wclk), .we(wr_en), .waddr(wptr_w[AW-1:0]), .wdata(din),
    .raddr(rptr_r[AW-1:0]), .rdata(rdata)
  );

  // The near-empty threshold is configuration: changed only while idle.
  dcf_rd_ctrl #(.AW(AW), .DW(DATA_W)) u_rd (
    .rclk(rclk), .rrst_n(r_rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .wgray_s(wgray_to_r), .rdata(rdata), .ae_thr(ae_thr),
    .rd_en(rd_en), .rptr(rptr_r), .rgray(rgray_r), .dout_q(dout_q),
    .empty(empty), .aempty(aempty)
  );

  assign dout = oe_n ? '0 : dout_q;
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
  parameter int PW = 7,
  parameter int DW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          w_rst_n,
  input logic          r_rst_n,
  input logic          wen1_n,
  input logic          wen2_ld,
  input logic          ren1_n,
  input logic          ren2_n,
  input logic          oe_n,
  input logic          full,
  input logic          afull,
  input logic          empty,
  input logic          aempty,
  input logic [DW-1:0] dout,
  input logic [PW-1:0] wptr_w,
  input logic [PW-1:0] rptr_r
);
  assert_write_step_R1: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (!wen1_n && wen2_ld && !full) |=> (wptr_w == $past(wptr_w) + PW'(1)));

  assert_read_gate_R2: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (ren1_n || ren2_n) |=> $stable(rptr_r));

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (full && !wen1_n && wen2_ld) |=> $stable(wptr_w));

  assert_no_underflow_R3: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (empty && !ren1_n && !ren2_n) |=> $stable(rptr_r));

  assert_empty_near_R5: assert property (@(posedge rclk) disable iff (!r_rst_n)
    empty |-> aempty);

  assert_full_near_R6: assert property (@(posedge wclk) disable iff (!w_rst_n)
    full |-> afull);

  assert_load_no_store_R7: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (!wen1_n && !wen2_ld) |=> $stable(wptr_w));

  assert_oe_blank_R8: assert property (@(posedge rclk) disable iff (!r_rst_n)
    oe_n |-> (dout == '0));
endmodule

bind dcfifo_pflag dcf_chk #(.PW(PW), .DW(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .wen1_n(wen1_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
  .oe_n(oe_n), .full(full), .afull(afull), .empty(empty), .aempty(aempty),
  .dout(dout), .wptr_w(wptr_w), .rptr_r(rptr_r)
);

// File: tb/tb_dcfifo_pflag.sv
`timescale 1ns/1ps
module tb_dcfifo_pflag;
  localparam int DEPTH = 64;
  localparam int DW    = 9;

  logic          wclk, aclk, rclk, tie;
  logic          rst_n, wen1_n, wen2_ld, ren1_n, ren2_n, oe_n;
  logic [DW-1:0] din, dout;
  logic          empty, full, aempty, afull;

  int n_chk, n_err, ae_o, af_o;
  bit done;

  dcfifo_pflag #(.DEPTH(DEPTH), .DATA_W(DW)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .oe_n(oe_n), .dout(dout), .empty(empty), .full(full),
    .aempty(aempty), .afull(afull)
  );

  initial begin wclk = 1'b0; forever #4 wclk = ~wclk; end
  initial begin aclk = 1'b0; forever #6.5 aclk = ~aclk; end
  assign rclk = tie ? wclk : aclk;

  function automatic logic [DW-1:0] dat(input int i);
    return DW'((i * 37 + 5) % 512);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_flags(input int occ);
    check("R4 empty", int'(empty), int'(occ == 0));
    check("R4 full", int'(full), int'(occ == DEPTH));
    check("R5 aempty", int'(aempty), int'(occ <= ae_o));
    check("R6 afull", int'(afull), int'((DEPTH - occ) <= af_o));
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wen1_n = 1'b0; wen2_ld = 1'b1; din = d;
    @(negedge wclk);
    wen1_n = 1'b1;
  endtask

  task automatic ld(input logic [DW-1:0] d);
    @(negedge wclk);
    wen1_n = 1'b0; wen2_ld = 1'b0; din = d;
    @(negedge wclk);
    wen1_n = 1'b1; wen2_ld = 1'b1;
  endtask

  task automatic rd(output logic [DW-1:0] q);
    @(negedge rclk);
    ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    q = dout;
  endtask

  task automatic do_reset(input logic tie_v);
    @(negedge wclk);
    rst_n = 1'b0;
    wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    #20 tie = tie_v;
    #20 rst_n = 1'b1;
    ae_o = 7; af_o = 7;
    settle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    n_chk = 0; n_err = 0; done = 1'b0;
    tie = 1'b1; rst_n = 1'b0; oe_n = 1'b0; din = '0;
    wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    do_reset(1'b1);

    // R9: state after reset
    check_flags(0);
    check("R9 dout reset", int'(dout), 0);

    // R7: two loads set near-empty=3 then near-full=5, no word stored
    ld(9'd3); ld(9'd5); ae_o = 3; af_o = 5;
    settle();
    check("R7 load stores no word", int'(empty), 1);

    // R1/R4/R5/R6: fill sweep over every occupancy
    check_flags(0);
    for (int n = 1; n <= DEPTH; n++) begin
      wr(dat(n - 1));
      settle();
      check_flags(n);
    end

    // R3: write while full is ignored
    wr(9'h1AA);
    settle();
    check_flags(DEPTH);

    // R1/R4/R5/R6: drain sweep, order and flags
    for (int i = 0; i < DEPTH; i++) begin
      rd(q);
      check("R1 order", int'(q), int'(dat(i)));
      settle();
      check_flags(DEPTH - 1 - i);
    end

    // R3: read while empty leaves output register
    rd(q);
    check("R3 empty read holds dout", int'(q), int'(dat(DEPTH - 1)));
    settle();
    check("R3 still empty", int'(empty), 1);

    // R2: half-qualified reads do nothing
    wr(9'h055);
    settle();
    @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b1;
    @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b0;
    @(negedge rclk); ren2_n = 1'b1;
    settle();
    check("R2 no read on partial enable", int'(empty), 0);
    check("R2 dout unchanged", int'(dout), int'(dat(DEPTH - 1)));

    // R1: wen1_n high stores nothing
    @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1; din = 9'h0AA;
    @(negedge wclk);
    settle();
    rd(q);
    check("R1 stored word", int'(q), 'h055);
    settle();
    check("R1 wen1_n high ignored", int'(empty), 1);

    // R8: output enable
    @(negedge rclk); oe_n = 1'b1;
    @(negedge rclk);
    check("R8 oe_n high blanks", int'(dout), 0);
    oe_n = 1'b0;
    @(negedge rclk);
    check("R8 oe_n low shows", int'(dout), 'h055);

    // R7: wrap of the load sequence (next load goes to near-empty)
    ld(9'd10); ld(9'd2); ld(9'd1); ae_o = 1; af_o = 2;
    wr(dat(0)); wr(dat(1));
    settle();
    check("R7 wrap near-empty", int'(aempty), 0);
    for (int n = 3; n <= 61; n++) wr(dat(n));
    settle();
    check("R7 near-full below", int'(afull), 0);
    wr(dat(62));
    settle();
    check("R7 near-full at", int'(afull), 1);

    // R9: reset mid-run restores defaults and the load sequence
    do_reset(1'b1);
    check_flags(0);
    for (int n = 1; n <= 7; n++) wr(dat(n));
    settle();
    check("R9 default near-empty at 7", int'(aempty), 1);
    wr(dat(8));
    settle();
    check("R9 default near-empty at 8", int'(aempty), 0);
    for (int n = 9; n <= 56; n++) wr(dat(n));
    settle();
    check("R9 default near-full at 56", int'(afull), 0);
    wr(dat(57));
    settle();
    check("R9 default near-full at 57", int'(afull), 1);
    ld(9'd60); ae_o = 60;
    settle();
    check("R9 load sequence restart", int'(aempty), 1);
    check_flags(57);

    // R10: simultaneous read and write, tied clocks
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) wr(dat(200 + i));
    settle();
    @(negedge wclk);
    for (int k = 0; k < 30; k++) begin
      wen1_n = 1'b0; wen2_ld = 1'b1; din = dat(204 + k);
      ren1_n = 1'b0; ren2_n = 1'b0;
      @(negedge wclk);
      check("R10 same-cycle order", int'(dout), int'(dat(200 + k)));
    end
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    settle();
    check_flags(4);
    for (int i = 0; i < 4; i++) begin
      rd(q);
      check("R10 tail order", int'(q), int'(dat(230 + i)));
    end
    settle();
    check_flags(0);

    // R10: independent clocks, concurrent producer and consumer
    do_reset(1'b0);
    fork
      begin
        for (int i = 0; i < 40; i++) wr(dat(100 + i));
      end
      begin
        int got;
        got = 0;
        while (got < 40) begin
          @(negedge rclk);
          if (!empty) begin
            ren1_n = 1'b0; ren2_n = 1'b0;
            @(negedge rclk);
            ren1_n = 1'b1; ren2_n = 1'b1;
            check("R10 async order", int'(dout), int'(dat(100 + got)));
            got++;
          end
        end
      end
    join
    settle();
    check_flags(0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule